// File: doc/BRIEF.md
# Instruction Prefix Front End

This block sits between the instruction byte stream and the opcode decoder of a 16-bit segmented processor. When told to start at a given instruction pointer, it fetches bytes from the code segment one at a time through a request/acknowledge handshake. It absorbs any segment-override and repeat prefixes that come before the opcode. It then presents one record to downstream decode: the opcode byte, the ModR/M byte when that opcode carries one, the selected segment with its base value, the repeat mode, and the cycle cost of the prefixes.

The first segment override in a prefix chain is the one kept. When there is no override, the record says "default", so that address generation can choose DS or SS itself. The repeat mode has three states. A byte that is neither a prefix nor a known opcode is reported as illegal, and any prefix state gathered before it is dropped. The block does not fetch immediates and does not execute anything.

Top module: `pfx_front`

## Requirements
- R1: After reset the block is idle. `fetch_req_o` and `rec_valid_o` are low, and a start request is accepted only while the block is idle.
- R2: The prefix bytes 0x26, 0x2E, 0x36 and 0x3E select ES, CS, SS and DS. In the record these are `seg_sel_o` = 1, 2, 3 and 4, and `seg_base_o` carries the matching segment input.
- R3: When several segment overrides come before one opcode, the first one is kept and the later ones have no effect.
- R4: With no override, `seg_sel_o` is 0 (default) and `seg_base_o` is 0.
- R5: Byte 0xF3 sets the repeat mode to 1 (while-equal) and 0xF2 sets it to 2 (while-not-equal). With neither, the mode is 0. When both appear, the last repeat prefix decides the mode.
- R6: The segment selection, repeat mode and prefix cost all return to their empty values at the start of every instruction.
- R7: Every fetch address is (CS × 16 + IP) mod 2^20. IP advances by one, modulo 2^16, for every byte consumed. At the end of an instruction, `ip_o` is the start IP plus the number of bytes consumed.
- R8: A ModR/M byte is fetched, and `has_modrm_o` is set, exactly for these opcodes: 0x38–0x3B, 0x62, 0x63, 0x80, 0x81, 0x83, 0x88–0x8F, 0xC6, 0xC7, 0xD0–0xD3, 0xFE and 0xFF. When there is no ModR/M byte, `modrm_o` is 0.
- R9: The recognised opcodes without ModR/M are 0x06, 0x07, 0x0E, 0x16, 0x17, 0x1E, 0x1F, 0x3C, 0x3D, 0x40–0x61, 0x70–0x7F, 0x90, 0xA0–0xA7, 0xAA–0xAF, 0xB0–0xBF, 0xC3, 0xCD, 0xE3, 0xE8, 0xE9, 0xEB, 0xF5, 0xF8, 0xF9, 0xFC and 0xFD. Any other non-prefix byte sets `illegal_o`, ends the instruction, and clears the segment selection, repeat mode and cost to 0.
- R10: `pfx_cycles_o` adds 2 for each segment-override prefix and 0 for each repeat prefix. It saturates at its all-ones value.
- R11: While a fetch is requested and not acknowledged, the request stays high and the address does not change.
- R12: `rec_valid_o` is a one-cycle pulse in the cycle after the last byte of the instruction is acknowledged. The record stays unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin gathering a new instruction |
| ip_i | input | 16 | Starting instruction pointer |
| seg_es_i | input | 16 | ES value |
| seg_cs_i | input | 16 | CS value, also used for fetch |
| seg_ss_i | input | 16 | SS value |
| seg_ds_i | input | 16 | DS value |
| fetch_req_o | output | 1 | Byte fetch request |
| fetch_addr_o | output | 20 | Linear fetch address |
| fetch_ack_i | input | 1 | Fetch data valid this cycle |
| fetch_data_i | input | 8 | Fetched byte |
| rec_valid_o | output | 1 | Record ready pulse |
| opcode_o | output | 8 | Opcode byte |
| has_modrm_o | output | 1 | ModR/M byte present |
| modrm_o | output | 8 | ModR/M byte |
| seg_sel_o | output | 3 | 0 default, 1 ES, 2 CS, 3 SS, 4 DS |
| seg_base_o | output | 16 | Value of the selected segment |
| rep_o | output | 2 | 0 none, 1 while-equal, 2 while-not-equal |
| illegal_o | output | 1 | Unrecognised opcode |
| pfx_cycles_o | output | 6 | Prefix cycle cost |
| ip_o | output | 16 | IP after the consumed bytes |

## Verification
The bench sweeps every one of the 256 possible first bytes. This separates prefixes, opcodes with ModR/M, opcodes without it and illegal bytes, and checks the byte count and the final IP for each. It then runs every ordered pair of the six prefix bytes in front of an opcode that carries ModR/M, with fetch stalls inserted. This shows first-wins for segments, last-wins for repeat, and the cost arithmetic. Further runs cover long override chains that saturate the cost, IP and address wrap at the top of the segment, prefixes followed by an illegal byte, and a plain instruction right after a prefixed one, which shows that prefix state does not leak between instructions.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  typedef enum logic [2:0] {
    SEG_DEF = 3'd0, SEG_ES = 3'd1, SEG_CS = 3'd2, SEG_SS = 3'd3, SEG_DS = 3'd4
  } seg_sel_e;

  typedef enum logic [1:0] {
    REP_NONE = 2'd0, REP_EQ = 2'd1, REP_NE = 2'd2
  } rep_e;

  typedef enum logic [2:0] {
    BK_PLAIN, BK_MODRM, BK_SEG, BK_REP, BK_BAD
  } byte_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_OP, ST_MR, ST_DONE
  } fsm_e;
endpackage

// File: rtl/pfx_byte_class.sv
module pfx_byte_class
  import pfx_pkg::*;
(
  input  logic [7:0] byte_i,
  output byte_kind_e kind_o,
  output seg_sel_e   seg_o,
  output rep_e       rep_o
);
  function automatic logic needs_modrm(input logic [7:0] b);
    return (b >= 8'h38 && b <= 8'h3B) || b == 8'h62 || b == 8'h63 ||
           b == 8'h80 || b == 8'h81 || b == 8'h83 ||
           (b >= 8'h88 && b <= 8'h8F) || b == 8'hC6 || b == 8'hC7 ||
           (b >= 8'hD0 && b <= 8'hD3) || b == 8'hFE || b == 8'hFF;
  endfunction

  function automatic logic is_plain(input logic [7:0] b);
    return b == 8'h06 || b == 8'h07 || b == 8'h0E || b == 8'h16 ||
           b == 8'h17 || b == 8'h1E || b == 8'h1F || b == 8'h3C ||
           b == 8'h3D || (b >= 8'h40 && b <= 8'h61) ||
           (b >= 8'h70 && b <= 8'h7F) || b == 8'h90 ||
           (b >= 8'hA0 && b <= 8'hA7) || (b >= 8'hAA && b <= 8'hAF) ||
           (b >= 8'hB0 && b <= 8'hBF) || b == 8'hC3 || b == 8'hCD ||
           b == 8'hE3 || b == 8'hE8 || b == 8'hE9 || b == 8'hEB ||
           b == 8'hF5 || b == 8'hF8 || b == 8'hF9 || b == 8'hFC ||
           b == 8'hFD;
  endfunction

  always_comb begin
    seg_o = SEG_DEF;
    rep_o = REP_NONE;
    unique case (byte_i)
      8'h26: begin kind_o = BK_SEG; seg_o = SEG_ES; end
      8'h2E: begin kind_o = BK_SEG; seg_o = SEG_CS; end
      8'h36: begin kind_o = BK_SEG; seg_o = SEG_SS; end
      8'h3E: begin kind_o = BK_SEG; seg_o = SEG_DS; end
      8'hF3: begin kind_o = BK_REP; rep_o = REP_EQ; end
      8'hF2: begin kind_o = BK_REP; rep_o = REP_NE; end
      default: begin
        if (needs_modrm(byte_i))   kind_o = BK_MODRM;
        else if (is_plain(byte_i)) kind_o = BK_PLAIN;
        else                       kind_o = BK_BAD;
      end
    endcase
  end
endmodule

// File: rtl/pfx_state.sv
module pfx_state
  import pfx_pkg::*;
#(
  parameter int CYC_W    = 6,
  parameter int SEG_COST = 2,
  parameter int REP_COST = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  byte_kind_e       kind_i,
  input  seg_sel_e         seg_i,
  input  rep_e             rep_i,
  output seg_sel_e         seg_o,
  output rep_e             rep_o,
  output logic [CYC_W-1:0] cyc_o
);
  localparam logic [CYC_W:0] CYC_MAX = {1'b0, {CYC_W{1'b1}}};

  seg_sel_e         seg_q;
  rep_e             rep_q;
  logic [CYC_W-1:0] cyc_q;
  logic [CYC_W:0]   cyc_sum;

  always_comb begin
    cyc_sum = {1'b0, cyc_q};
    if (kind_i == BK_SEG)      cyc_sum = cyc_sum + (CYC_W+1)'(SEG_COST);
    else if (kind_i == BK_REP) cyc_sum = cyc_sum + (CYC_W+1)'(REP_COST);
    if (cyc_sum > CYC_MAX)     cyc_sum = CYC_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= SEG_DEF;
      rep_q <= REP_NONE;
      cyc_q <= '0;
    end else if (clr_i) begin
      seg_q <= SEG_DEF;
      rep_q <= REP_NONE;
      cyc_q <= '0;
    end else if (take_i) begin
      unique case (kind_i)
        BK_SEG: begin
          if (seg_q == SEG_DEF) seg_q <= seg_i;  // first override wins
          cyc_q <= cyc_sum[CYC_W-1:0];
        end
        BK_REP: begin
          rep_q <= rep_i;
          cyc_q <= cyc_sum[CYC_W-1:0];
        end
        BK_BAD: begin
          seg_q <= SEG_DEF;
          rep_q <= REP_NONE;
          cyc_q <= '0;
        end
        default: ;
      endcase
    end
  end

  assign seg_o = seg_q;
  assign rep_o = rep_q;
  assign cyc_o = cyc_q;
endmodule

// File: rtl/pfx_fetch_ctrl.sv
module pfx_fetch_ctrl
  import pfx_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = SEG_W + SEG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SEG_W-1:0]  ip_i,
  input  logic [SEG_W-1:0]  cs_i,
  input  logic              ack_i,
  input  logic [7:0]        data_i,
  input  byte_kind_e        kind_i,
  output logic              clr_o,
  output logic              take_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic [7:0]        opcode_o,
  output logic              has_modrm_o,
  output logic [7:0]        modrm_o,
  output logic              illegal_o,
  output logic [SEG_W-1:0]  ip_o
);
  fsm_e             st_q;
  logic [SEG_W-1:0] ip_q;
  logic [7:0]       op_q, mr_q;
  logic             hm_q, ill_q;

  assign clr_o  = (st_q == ST_IDLE) && start_i;
  assign take_o = (st_q == ST_OP) && ack_i;
  assign req_o  = (st_q == ST_OP) || (st_q == ST_MR);
  assign addr_o = ({{SEG_SHIFT{1'b0}}, cs_i} << SEG_SHIFT) +
                  {{SEG_SHIFT{1'b0}}, ip_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ip_q  <= '0;
      op_q  <= '0;
      mr_q  <= '0;
      hm_q  <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          ip_q  <= ip_i;
          op_q  <= '0;
          mr_q  <= '0;
          hm_q  <= 1'b0;
          ill_q <= 1'b0;
          st_q  <= ST_OP;
        end
        ST_OP: if (ack_i) begin
          ip_q <= ip_q + 1'b1;
          unique case (kind_i)
            BK_SEG, BK_REP: ;
            BK_MODRM: begin op_q <= data_i; hm_q <= 1'b1; st_q <= ST_MR; end
            BK_PLAIN: begin op_q <= data_i; st_q <= ST_DONE; end
            default:  begin op_q <= data_i; ill_q <= 1'b1; st_q <= ST_DONE; end
          endcase
        end
        ST_MR: if (ack_i) begin
          ip_q <= ip_q + 1'b1;
          mr_q <= data_i;
          st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o     = (st_q == ST_DONE);
  assign opcode_o    = op_q;
  assign has_modrm_o = hm_q;
  assign modrm_o     = mr_q;
  assign illegal_o   = ill_q;
  assign ip_o        = ip_q;
endmodule

// File: rtl/pfx_front.sv
module pfx_front
  import pfx_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int CYC_W     = 6,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SEG_W-1:0]  ip_i,
  input  logic [SEG_W-1:0]  seg_es_i,
  input  logic [SEG_W-1:0]  seg_cs_i,
  input  logic [SEG_W-1:0]  seg_ss_i,
  input  logic [SEG_W-1:0]  seg_ds_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_ack_i,
  input  logic [7:0]        fetch_data_i,
  output logic              rec_valid_o,
  output logic [7:0]        opcode_o,
  output logic              has_modrm_o,
  output logic [7:0]        modrm_o,
  output logic [2:0]        seg_sel_o,
  output logic [SEG_W-1:0]  seg_base_o,
  output logic [1:0]        rep_o,
  output logic              illegal_o,
  output logic [CYC_W-1:0]  pfx_cycles_o,
  output logic [SEG_W-1:0]  ip_o
);
  byte_kind_e kind;
  seg_sel_e   byte_seg, cur_seg;
  rep_e       byte_rep, cur_rep;
  logic       clr, take;

  pfx_byte_class u_class (
    .byte_i(fetch_data_i), .kind_o(kind), .seg_o(byte_seg), .rep_o(byte_rep)
  );

  pfx_state #(.CYC_W(CYC_W)) u_state (
    .clk_i, .rst_ni, .clr_i(clr), .take_i(take), .kind_i(kind),
    .seg_i(byte_seg), .rep_i(byte_rep),
    .seg_o(cur_seg), .rep_o(cur_rep), .cyc_o(pfx_cycles_o)
  );

  pfx_fetch_ctrl #(.SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .ip_i, .cs_i(seg_cs_i),
    .ack_i(fetch_ack_i), .data_i(fetch_data_i), .kind_i(kind),
    .clr_o(clr), .take_o(take), .req_o(fetch_req_o), .addr_o(fetch_addr_o),
    .valid_o(rec_valid_o), .opcode_o, .has_modrm_o, .modrm_o,
    .illegal_o, .ip_o
  );

  always_comb begin
    unique case (cur_seg)
      SEG_ES:  seg_base_o = seg_es_i;
      SEG_CS:  seg_base_o = seg_cs_i;
      SEG_SS:  seg_base_o = seg_ss_i;
      SEG_DS:  seg_base_o = seg_ds_i;
      default: seg_base_o = '0;
    endcase
  end

  assign seg_sel_o = cur_seg;
  assign rep_o     = cur_rep;
endmodule

// File: rtl/pfx_front_chk.sv
module pfx_front_chk #(
  parameter int SEG_W  = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_req_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              fetch_ack_i,
  input logic              rec_valid_o,
  input logic              has_modrm_o,
  input logic [2:0]        seg_sel_o,
  input logic [SEG_W-1:0]  seg_base_o,
  input logic [1:0]        rep_o,
  input logic              illegal_o,
  input logic [SEG_W-1:0]  ip_o
);
  assert_stall_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && !fetch_ack_i |=> fetch_req_o && $stable(fetch_addr_o));
  assert_ip_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && fetch_ack_i |=> ip_o == $past(ip_o) + 1'b1);
  assert_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o);
  assert_no_fetch_on_rec_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> !fetch_req_o);
  assert_illegal_clean_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && illegal_o |-> seg_sel_o == 3'd0 && rep_o == 2'd0 && !has_modrm_o);
  assert_default_base_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && seg_sel_o == 3'd0 |-> seg_base_o == '0);
  assert_rep_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> rep_o != 2'd3);
  assert_seg_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> seg_sel_o <= 3'd4);
endmodule

bind pfx_front pfx_front_chk #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .fetch_req_o, .fetch_addr_o, .fetch_ack_i, .rec_valid_o,
  .has_modrm_o, .seg_sel_o, .seg_base_o, .rep_o, .illegal_o, .ip_o
);

// File: tb/pfx_front_tb_top.sv
`timescale 1ns/1ps
module pfx_front_tb_top;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ip_in = '0, es = 16'h1111, cs = 16'h2222, ss = 16'h3333, ds = 16'h4444;
  logic        req, ack = 1'b0, vld, hm, ill;
  logic [19:0] addr;
  logic [7:0]  data = '0, opc, mr;
  logic [2:0]  sel;
  logic [15:0] base, ipo;
  logic [1:0]  rep;
  logic [5:0]  cyc;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] prog [64];
  bit stall_en = 0;

  always #4 clk = ~clk;

  pfx_front dut_i (
    .clk_i(clk), .rst_ni, .start_i(start), .ip_i(ip_in),
    .seg_es_i(es), .seg_cs_i(cs), .seg_ss_i(ss), .seg_ds_i(ds),
    .fetch_req_o(req), .fetch_addr_o(addr), .fetch_ack_i(ack),
    .fetch_data_i(data), .rec_valid_o(vld), .opcode_o(opc),
    .has_modrm_o(hm), .modrm_o(mr), .seg_sel_o(sel), .seg_base_o(base),
    .rep_o(rep), .illegal_o(ill), .pfx_cycles_o(cyc), .ip_o(ipo)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic bit spec_modrm(input logic [7:0] b);
    return (b >= 8'h38 && b <= 8'h3B) || b == 8'h62 || b == 8'h63 || b == 8'h80 ||
           b == 8'h81 || b == 8'h83 || (b >= 8'h88 && b <= 8'h8F) || b == 8'hC6 ||
           b == 8'hC7 || (b >= 8'hD0 && b <= 8'hD3) || b == 8'hFE || b == 8'hFF;
  endfunction

  function automatic bit spec_plain(input logic [7:0] b);
    return b == 8'h06 || b == 8'h07 || b == 8'h0E || b == 8'h16 || b == 8'h17 ||
           b == 8'h1E || b == 8'h1F || b == 8'h3C || b == 8'h3D ||
           (b >= 8'h40 && b <= 8'h61) || (b >= 8'h70 && b <= 8'h7F) || b == 8'h90 ||
           (b >= 8'hA0 && b <= 8'hA7) || (b >= 8'hAA && b <= 8'hAF) ||
           (b >= 8'hB0 && b <= 8'hBF) || b == 8'hC3 || b == 8'hCD || b == 8'hE3 ||
           b == 8'hE8 || b == 8'hE9 || b == 8'hEB || b == 8'hF5 || b == 8'hF8 ||
           b == 8'hF9 || b == 8'hFC || b == 8'hFD;
  endfunction

  // Runs one instruction from prog[] and compares against a model walk of prog[].
  task automatic run(input logic [15:0] ip0);
    int e_sel = 0, e_rep = 0, e_cyc = 0, n = 0, k = 0, t = 0, sctr = 0;
    bit e_hm = 0, e_ill = 0, done = 0;
    logic [7:0] e_op = 0, e_mr = 0, b;
    logic [15:0] e_base;
    while (!done) begin
      b = prog[n]; n++;
      case (b)
        8'h26: begin if (e_sel == 0) e_sel = 1; e_cyc += 2; end
        8'h2E: begin if (e_sel == 0) e_sel = 2; e_cyc += 2; end
        8'h36: begin if (e_sel == 0) e_sel = 3; e_cyc += 2; end
        8'h3E: begin if (e_sel == 0) e_sel = 4; e_cyc += 2; end
        8'hF3: e_rep = 1;
        8'hF2: e_rep = 2;
        default: begin
          e_op = b; done = 1;
          if (spec_modrm(b)) begin e_hm = 1; e_mr = prog[n]; n++; end
          else if (!spec_plain(b)) begin e_ill = 1; e_sel = 0; e_rep = 0; e_cyc = 0; end
        end
      endcase
    end
    if (e_cyc > 63) e_cyc = 63;
    e_base = e_sel == 1 ? es : e_sel == 2 ? cs : e_sel == 3 ? ss : e_sel == 4 ? ds : 16'h0;

    @(negedge clk); ip_in = ip0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    forever begin
      if (vld) break;
      if (t++ > 400) begin chk(0, "R12 no record", 0, 1); return; end
      ack = 1'b0;
      if (req) begin
        sctr++;
        if (!(stall_en && sctr % 3 == 0)) begin
          chk(addr == 20'(({4'h0, cs} << 4) + {4'h0, 16'(ip0 + k)}), "R7 addr", addr,
              20'(({4'h0, cs} << 4) + {4'h0, 16'(ip0 + k)}));
          ack = 1'b1; data = prog[k]; k++;
        end
      end
      @(negedge clk);
    end
    ack = 1'b0;
    chk(k == n, "R8 bytes consumed", k, n);
    chk(opc == e_op, "R9 opcode", opc, e_op);
    chk(hm == e_hm, "R8 has_modrm", hm, e_hm);
    chk(mr == e_mr, "R8 modrm", mr, e_mr);
    chk(ill == e_ill, "R9 illegal", ill, e_ill);
    chk(sel == 3'(e_sel), "R3 seg_sel", sel, e_sel);
    chk(base == e_base, "R2 seg_base", base, e_base);
    chk(rep == 2'(e_rep), "R5 rep", rep, e_rep);
    chk(cyc == 6'(e_cyc), "R10 cycles", cyc, e_cyc);
    chk(ipo == 16'(ip0 + n), "R7 ip_o", ipo, 16'(ip0 + n));
    @(negedge clk);
    chk(!vld && sel == 3'(e_sel), "R12 pulse/hold", vld, 0);
  endtask

  initial begin
    automatic logic [7:0] pf [6] = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'hF3, 8'hF2};
    repeat (3) @(negedge clk);
    chk(!req && !vld, "R1 reset idle", {req, vld}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!req && !vld, "R1 idle after reset", {req, vld}, 0);
    cs = 16'h1234;
    // R8/R9: every first byte
    for (int op = 0; op < 256; op++) begin
      prog[0] = 8'(op); prog[1] = 8'hC5; prog[2] = 8'h90;
      run(16'h0100);
    end
    // R3/R5/R10/R11: every ordered prefix pair, with stalls
    stall_en = 1;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        prog[0] = pf[i]; prog[1] = pf[j]; prog[2] = 8'h8B; prog[3] = 8'h5A;
        run(16'h7F00);
        // R6: following plain instruction sees no leftover prefix state
        prog[0] = 8'h40; run(16'h0010);
      end
    stall_en = 0;
    // R10 saturation
    for (int i = 0; i < 40; i++) prog[i] = (i % 2) ? 8'h36 : 8'h26;
    prog[40] = 8'h90;
    run(16'h0200);
    // R7 wrap of IP and address
    cs = 16'hFFFF;
    prog[0] = 8'h2E; prog[1] = 8'h3E; prog[2] = 8'hFF; prog[3] = 8'h07;
    run(16'hFFFE);
    // R9 illegal after prefixes
    cs = 16'h0040;
    prog[0] = 8'h26; prog[1] = 8'hF3; prog[2] = 8'h0F;
    run(16'h0000);
    // R1 start ignored while busy: second start mid-fetch must not restart
    prog[0] = 8'h26; prog[1] = 8'h90;
    @(negedge clk); ip_in = 16'h0500; start = 1'b1;
    @(negedge clk); ip_in = 16'h0900;
    @(negedge clk); start = 1'b0;
    chk(req && addr == 20'h00900 + 20'h00500 - 20'h00900 + 20'h00400, "R1 busy start ignored",
        addr, 20'h00900);
    ack = 1'b1; data = 8'h90;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
    chk(ipo == 16'h0501, "R1 ip after busy start", ipo, 16'h0501);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule